// File: doc/BRIEF.md
# Predicated Sub-Vector Element Sequencer

This block turns one scalar-encoded operation into a stream of element operations. A start pulse captures a vector length, a sub-vector length, a predicate mask word, three base register numbers and one vector-or-scalar flag per operand. The block then walks an outer loop over elements and, inside each element, an inner loop over sub-elements. It produces one sub-operation per clock cycle. For each step it drives the destination and two source register numbers and an issue strobe that is gated by the predicate.

The element and sub-element counters are visible at the ports, so surrounding logic can save them as context if the loop is interrupted. When the loop ends, both counters return to zero and a one-cycle done pulse is raised. The arithmetic unit and the register file sit outside this block.

Top module: `subvec_loop_seq`

## Requirements
- R1: After reset, busy, done and the issue strobe are low, and both the element offset and the sub-element offset read 0.
- R2: A start sampled at a clock edge while idle makes busy high and the first step visible right after that edge. Each following edge advances the loop by exactly one sub-operation.
- R3: Each element spans exactly SUBVL consecutive steps. During those steps the sub-element offset counts 0 up to SUBVL-1 and the element offset holds still. The sub-element loop is the innermost loop.
- R4: The issue strobe of every step of element i equals bit i of the predicate mask (bit 0 belongs to element 0). A step whose bit is clear still takes one cycle, with the strobe low.
- R5: Each issued register number is that operand's base plus its operand index, modulo 2^REG_W. Every index starts at 0. After each element, an index moves up by one only when that operand's vector flag is 1.
- R6: When the destination flag is 0 (scalar), the loop ends after the last step of the first element whose predicate bit is set.
- R7: Otherwise the loop ends after the element at which any operand index, or the element count, reaches VL.
- R8: On the clock edge after the last step, busy falls and done is high for exactly one cycle. At that point both offsets read 0.
- R9: A start that arrives while busy is ignored. The configuration captured at the accepted start stays in force for the rest of the loop.
- R10: vl is an unsigned value from 1 to MAX_VL, and subvl is an unsigned value from 1 to MAX_SUBVL. Both limits work, including a single-element, single-sub-element operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a loop when idle |
| vl | input | VL_W (6) | Element count, 1..MAX_VL |
| subvl | input | SUB_W (3) | Sub-elements per element, 1..MAX_SUBVL |
| predMask | input | XLEN (64) | Predicate word, bit i gates element i |
| baseRd | input | REG_W (7) | Destination base register number |
| baseRs1 | input | REG_W (7) | First source base register number |
| baseRs2 | input | REG_W (7) | Second source base register number |
| rdIsVec | input | 1 | Destination is a vector |
| rs1IsVec | input | 1 | First source is a vector |
| rs2IsVec | input | 1 | Second source is a vector |
| issueValid | output | 1 | Current step is issued |
| issueRd | output | REG_W (7) | Destination register of current step |
| issueRs1 | output | REG_W (7) | First source register of current step |
| issueRs2 | output | REG_W (7) | Second source register of current step |
| elemOffs | output | ELEM_W (5) | Live element offset |
| subOffs | output | SOFF_W (2) | Live sub-element offset |
| busy | output | 1 | Loop running |
| done | output | 1 | One-cycle end pulse |

## Verification
Step outputs come straight from registers. The first step is therefore due in the cycle right after the edge that samples start, and each later step is due one edge after the one before it. The done pulse, the fall of busy and the cleared offsets all appear one edge after the last step, and done drops again on the following edge. The bench drives and samples on falling edges. It steps its own model one falling edge per predicted sub-operation, so every comparison lands in the middle of the cycle in which that result is held.

// File: rtl/subvec_seq_pkg.sv
package subvec_seq_pkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } seqState_t;

  // Strobes from control to the datapath
  typedef struct packed {
    logic load;    // capture configuration, zero counters
    logic step;    // advance by one sub-operation
    logic finish;  // this step is the last one
  } ctlStrobes_t;

endpackage

// File: rtl/subvec_seq_ctl.sv
module subvec_seq_ctl
  import subvec_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        endLoop,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);

  seqState_t state;

  always_comb begin
    ctl.load   = (state == S_IDLE) && start;
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_RUN) && endLoop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ctl.finish;
      case (state)
        S_IDLE:  if (ctl.load) state <= S_RUN;
        S_RUN:   if (ctl.finish) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_RUN);

  // R8: done never lasts two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done only while idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: a start while running keeps the loop running unless it is finishing
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !endLoop) |=> busy);

endmodule

// File: rtl/subvec_seq_dp.sv
module subvec_seq_dp
  import subvec_seq_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MAX_VL    = 32,
  parameter int MAX_SUBVL = 4,
  parameter int REG_W     = 7,
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int SUB_W    = $clog2(MAX_SUBVL + 1),
  localparam int ELEM_W   = $clog2(MAX_VL),
  localparam int SOFF_W   = (MAX_SUBVL > 1) ? $clog2(MAX_SUBVL) : 1,
  localparam int N_OPS    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              busyI,
  input  logic [VL_W-1:0]   vl,
  input  logic [SUB_W-1:0]  subvl,
  input  logic [XLEN-1:0]   predMask,
  input  logic [REG_W-1:0]  baseRd,
  input  logic [REG_W-1:0]  baseRs1,
  input  logic [REG_W-1:0]  baseRs2,
  input  logic              rdIsVec,
  input  logic              rs1IsVec,
  input  logic              rs2IsVec,
  output logic              endLoop,
  output logic              issueValid,
  output logic [REG_W-1:0]  issueRd,
  output logic [REG_W-1:0]  issueRs1,
  output logic [REG_W-1:0]  issueRs2,
  output logic [ELEM_W-1:0] elemOffs,
  output logic [SOFF_W-1:0] subOffs
);

  // Captured configuration
  logic [VL_W-1:0]  cfgVl;
  logic [SUB_W-1:0] cfgSub;
  logic [XLEN-1:0]  cfgMask;
  logic [REG_W-1:0] cfgBase [N_OPS];
  logic [N_OPS-1:0] cfgVec;

  // Loop state
  logic [ELEM_W-1:0] elem;
  logic [SOFF_W-1:0] sub;
  logic [VL_W-1:0]   idx     [N_OPS];
  logic [VL_W-1:0]   nextIdx [N_OPS];
  logic [REG_W-1:0]  regNum  [N_OPS];
  logic [N_OPS-1:0]  hitVl;

  logic lastSub, predBit, elemHit, scalarStop;

  assign lastSub    = (SUB_W'(sub) == (cfgSub - SUB_W'(1)));
  assign predBit    = cfgMask[elem];
  assign elemHit    = ((VL_W'(elem) + VL_W'(1)) == cfgVl);
  assign scalarStop = !cfgVec[0] && predBit;

  for (genvar op = 0; op < N_OPS; op++) begin : g_ops
    assign nextIdx[op] = idx[op] + VL_W'(cfgVec[op]);
    assign hitVl[op]   = cfgVec[op] && (nextIdx[op] == cfgVl);
    assign regNum[op]  = cfgBase[op] + REG_W'(idx[op]);
  end

  assign endLoop = lastSub && (scalarStop || elemHit || (|hitVl));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgVl   <= '0;
      cfgSub  <= '0;
      cfgMask <= '0;
      cfgVec  <= '0;
      elem    <= '0;
      sub     <= '0;
      for (int op = 0; op < N_OPS; op++) begin
        cfgBase[op] <= '0;
        idx[op]     <= '0;
      end
    end else if (ctl.load) begin
      cfgVl      <= vl;
      cfgSub     <= subvl;
      cfgMask    <= predMask;
      cfgVec     <= {rs2IsVec, rs1IsVec, rdIsVec};
      cfgBase[0] <= baseRd;
      cfgBase[1] <= baseRs1;
      cfgBase[2] <= baseRs2;
      elem       <= '0;
      sub        <= '0;
      for (int op = 0; op < N_OPS; op++) idx[op] <= '0;
    end else if (ctl.finish) begin
      elem <= '0;
      sub  <= '0;
      for (int op = 0; op < N_OPS; op++) idx[op] <= '0;
    end else if (ctl.step) begin
      if (lastSub) begin
        sub  <= '0;
        elem <= elem + ELEM_W'(1);
        for (int op = 0; op < N_OPS; op++) idx[op] <= nextIdx[op];
      end else begin
        sub <= sub + SOFF_W'(1);
      end
    end
  end

  assign issueValid = busyI && predBit;
  assign issueRd    = regNum[0];
  assign issueRs1   = regNum[1];
  assign issueRs2   = regNum[2];
  assign elemOffs   = elem;
  assign subOffs    = sub;

  // R3: sub-element offset stays below SUBVL while running
  p_sub_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busyI |-> (SUB_W'(sub) < cfgSub));

  // R3: within an element the sub offset counts up by one
  p_sub_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyI && $past(busyI) && sub != '0) |-> (sub == $past(sub) + SOFF_W'(1)));

  // R3: element offset holds inside an element
  p_elem_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyI && $past(busyI) && sub != '0) |-> $stable(elem));

  // R4: nothing issues while idle
  p_issue_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> busyI);

  // R9: configuration frozen while running
  p_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    busyI |=> ($stable(cfgVl) && $stable(cfgMask) && $stable(cfgSub)));

endmodule

// File: rtl/subvec_loop_seq.sv
module subvec_loop_seq
  import subvec_seq_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MAX_VL    = 32,
  parameter int MAX_SUBVL = 4,
  parameter int REG_W     = 7,
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int SUB_W    = $clog2(MAX_SUBVL + 1),
  localparam int ELEM_W   = $clog2(MAX_VL),
  localparam int SOFF_W   = (MAX_SUBVL > 1) ? $clog2(MAX_SUBVL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [SUB_W-1:0]  subvl,
  input  logic [XLEN-1:0]   predMask,
  input  logic [REG_W-1:0]  baseRd,
  input  logic [REG_W-1:0]  baseRs1,
  input  logic [REG_W-1:0]  baseRs2,
  input  logic              rdIsVec,
  input  logic              rs1IsVec,
  input  logic              rs2IsVec,
  output logic              issueValid,
  output logic [REG_W-1:0]  issueRd,
  output logic [REG_W-1:0]  issueRs1,
  output logic [REG_W-1:0]  issueRs2,
  output logic [ELEM_W-1:0] elemOffs,
  output logic [SOFF_W-1:0] subOffs,
  output logic              busy,
  output logic              done
);

  ctlStrobes_t ctl;
  logic        endLoop;

  subvec_seq_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .endLoop (endLoop),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  subvec_seq_dp #(
    .XLEN      (XLEN),
    .MAX_VL    (MAX_VL),
    .MAX_SUBVL (MAX_SUBVL),
    .REG_W     (REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busyI      (busy),
    .vl         (vl),
    .subvl      (subvl),
    .predMask   (predMask),
    .baseRd     (baseRd),
    .baseRs1    (baseRs1),
    .baseRs2    (baseRs2),
    .rdIsVec    (rdIsVec),
    .rs1IsVec   (rs1IsVec),
    .rs2IsVec   (rs2IsVec),
    .endLoop    (endLoop),
    .issueValid (issueValid),
    .issueRd    (issueRd),
    .issueRs1   (issueRs1),
    .issueRs2   (issueRs2),
    .elemOffs   (elemOffs),
    .subOffs    (subOffs)
  );

  // R8: offsets read zero when the done pulse is up
  p_offs_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (elemOffs == '0 && subOffs == '0));

endmodule

// File: tb/tb_subvec_loop_seq.sv
module tb_subvec_loop_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  vl = 6'd1;
  logic [2:0]  subvl = 3'd1;
  logic [63:0] predMask = '0;
  logic [6:0]  baseRd = '0, baseRs1 = '0, baseRs2 = '0;
  logic        rdIsVec = 1'b0, rs1IsVec = 1'b0, rs2IsVec = 1'b0;
  logic        issueValid;
  logic [6:0]  issueRd, issueRs1, issueRs2;
  logic [4:0]  elemOffs;
  logic [1:0]  subOffs;
  logic        busy, done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  subvec_loop_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .vl(vl), .subvl(subvl),
    .predMask(predMask), .baseRd(baseRd), .baseRs1(baseRs1), .baseRs2(baseRs2),
    .rdIsVec(rdIsVec), .rs1IsVec(rs1IsVec), .rs2IsVec(rs2IsVec),
    .issueValid(issueValid), .issueRd(issueRd), .issueRs1(issueRs1),
    .issueRs2(issueRs2), .elemOffs(elemOffs), .subOffs(subOffs),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Packed view of step outputs: valid, rd, rs1, rs2, elem, sub, busy, done
  function automatic logic [31:0] stepView(logic v, logic [6:0] d, logic [6:0] a,
      logic [6:0] b, logic [4:0] e, logic [1:0] s, logic bz, logic dn);
    return {8'd0, v, d, a, b, e, s, bz, dn};
  endfunction

  // Runs one operation and compares every step against a model built from R2-R9.
  // midStartAt: step number at which a stray start is pulsed (-1 for none).
  task automatic runOp(input string name, input int vlV, input int subV,
      input logic [63:0] mask, input logic [6:0] bd, input logic [6:0] b1,
      input logic [6:0] b2, input logic vd, input logic v1, input logic v2,
      input int midStartAt);
    int id = 0, i1 = 0, i2 = 0, e = 0, stepNo = 0;
    bit fin = 1'b0;
    logic [31:0] expV, actV;
    @(negedge clk);
    vl = 6'(vlV); subvl = 3'(subV); predMask = mask;
    baseRd = bd; baseRs1 = b1; baseRs2 = b2;
    rdIsVec = vd; rs1IsVec = v1; rs2IsVec = v2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin) begin
      for (int s = 0; s < subV; s++) begin
        expV = stepView(mask[e], 7'(bd + id), 7'(b1 + i1), 7'(b2 + i2),
                        5'(e), 2'(s), 1'b1, 1'b0);
        actV = stepView(issueValid, issueRd, issueRs1, issueRs2,
                        elemOffs, subOffs, busy, done);
        chk(actV == expV, "R2 R3 R4 R5", name, 64'(actV), 64'(expV));
        if (stepNo == midStartAt) begin
          start = 1'b1;          // R9: stray start with altered inputs
          vl = 6'd1; predMask = '0; subvl = 3'd1;
        end else begin
          start = 1'b0;
        end
        stepNo++;
        @(negedge clk);
      end
      if (!vd && mask[e]) fin = 1'b1;  // R6
      else begin
        id += int'(vd); i1 += int'(v1); i2 += int'(v2); e++;
        if (id == vlV || i1 == vlV || i2 == vlV || e == vlV) fin = 1'b1;  // R7
      end
    end
    start = 1'b0;
    // R8 and R9: done one edge after last step, idle, offsets cleared
    chk(done == 1'b1 && busy == 1'b0 && elemOffs == 0 && subOffs == 0 && !issueValid,
        "R8 R9", {name, " end"}, {59'd0, done, busy, issueValid, |elemOffs, |subOffs},
        64'h10);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {name, " done width"},
        {62'd0, done, busy}, 64'h0);
  endtask

  task automatic testReset();
    chk(!busy && !done && !issueValid && elemOffs == 0 && subOffs == 0, "R1",
        "reset state", {59'd0, busy, done, issueValid, |elemOffs, |subOffs}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R2 R3 R5 R7: all vector operands, full mask
    runOp("all vector", 4, 3, 64'hF, 7'd8, 7'd40, 7'd100, 1, 1, 1, -1);
    // R4: sparse mask, scalar second source
    runOp("sparse mask", 8, 2, 64'hA5, 7'd10, 7'd20, 7'd30, 1, 1, 0, -1);
    // R6: scalar destination stops after first issued element
    runOp("scalar dest", 8, 2, 64'h8, 7'd5, 7'd50, 7'd60, 0, 1, 1, -1);
    // R6: scalar destination, element 0 issued
    runOp("scalar dest first", 6, 3, 64'h1, 7'd1, 7'd2, 7'd3, 0, 1, 0, -1);
    // R7: everything scalar, mask clear, ends on element count
    runOp("all scalar", 5, 1, 64'h0, 7'd9, 7'd9, 7'd9, 0, 0, 0, -1);
    // R10: largest VL and SUBVL, with register number wraparound (R5)
    runOp("max lengths", 32, 4, 64'hDEADBEEF, 7'd120, 7'd100, 7'd0, 1, 1, 1, -1);
    // R10: smallest VL and SUBVL
    runOp("min lengths", 1, 1, 64'h1, 7'd3, 7'd4, 7'd5, 1, 1, 1, -1);
    // R9: stray start mid-run, and on the final step
    runOp("start mid run", 6, 2, 64'h3C, 7'd16, 7'd32, 7'd48, 1, 0, 1, 3);
    runOp("start last step", 3, 2, 64'h7, 7'd16, 7'd32, 7'd48, 1, 1, 1, 5);
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule